// File: doc/BRIEF.md
# Pulse-Count Feedback Reference Programmer

This block receives a one-wire control line from a host processor and sets the feedback-reference code of a step-up regulator from it. The host encodes a code as a number of pulses. The line first holds high for a start interval. It then sends the pulses as low/high pairs, and it ends the frame by holding high for a stop interval. The block counts the pulses. Once the stop interval has run and a short settling delay has passed, the count becomes the new code.

A long period with the line low reverts the code to its default, and so does dropping the enable input. All timing is measured in ticks of a free-running microsecond timebase, and every threshold is a parameter. The block drives three outputs: the 5-bit code, the reference it stands for in millivolts, and a one-clock strobe whenever the code changes.

Top module: `pulse_code_prog`

## Requirements
- R1: After reset `code` is 0, `ref_mv` is 800 and `code_upd` is low.
- R2: A completed frame of N pulses (N counted on falling edges of the filtered line, 1..30) sets `code` to N and `ref_mv` to 800 + 15*N. Pulse widths are not qualified: short (10-tick) and long (120-tick) phases both count.
- R3: Falling edges count only once the line has been high for at least START_TICKS (300) ticks. Line activity after a shorter high period leaves `code` unchanged.
- R4: A frame closes after the line has stayed high for STOP_TICKS (300) ticks. The new code appears DELAY_TICKS (20) ticks later, and not before.
- R5: Each frame replaces the code outright. A 2-pulse frame after a 4-pulse frame gives code 2 (830 mV).
- R6: Pulse counts above 30 saturate, so `code` never exceeds 30 (1250 mV). A repeated frame of the same count changes nothing.
- R7: Holding the line low for OFF_TICKS (270) ticks, either idle or inside a frame, returns `code` to 0.
- R8: While `en` is low, `code` is 0 and line activity has no effect.
- R9: A line glitch narrower than one tick period is filtered out and does not alter the pulse count.
- R10: `code_upd` is high for exactly the cycle in which the new `code` first appears, and only when the code value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable for the step-up section; low forces the default code |
| line_in | input | 1 | Asynchronous single-wire programming line |
| tick_us | input | 1 | One-clock pulse per timebase tick |
| code | output | 5 | Current reference code, 0..30 |
| ref_mv | output | 11 | Feedback reference in millivolts |
| code_upd | output | 1 | One-clock strobe on each code change |

## Verification
The assertions assume that `tick_us` is a single-cycle pulse with at least one idle cycle between ticks. They also assume that `en` is not dropped within a cycle of a frame being applied, so the code never changes on two consecutive cycles. The stimulus produces one tick every second clock. It holds `en` steady around every frame completion. It moves the line only on the falling clock edge, with phase lengths in whole ticks and glitches exactly one clock wide.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_READY,
    ST_FRAME,
    ST_HOLD
  } dec_state_e;
endpackage

// File: rtl/pcp_line_filter.sv
module pcp_line_filter #(
  parameter int FILT_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_raw,
  output logic line_flt
);
  localparam int FW = $clog2(FILT_TICKS + 1);

  logic          s1_q, s2_q, flt_q, flt_d;
  logic [FW-1:0] cnt_q, cnt_d;

  always_comb begin
    flt_d = flt_q;
    cnt_d = cnt_q;
    if (tick) begin
      if (s2_q == flt_q) begin
        cnt_d = '0;
      end else if (cnt_q == FW'(FILT_TICKS - 1)) begin
        flt_d = s2_q;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      flt_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q  <= line_raw;
      s2_q  <= s1_q;
      flt_q <= flt_d;
      cnt_q <= cnt_d;
    end
  end

  assign line_flt = flt_q;

  // R9
  flt_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(flt_q));
endmodule

// File: rtl/pcp_frame_dec.sv
module pcp_frame_dec
  import pcp_pkg::*;
#(
  parameter int START_TICKS = 300,
  parameter int STOP_TICKS  = 300,
  parameter int OFF_TICKS   = 270,
  parameter int DELAY_TICKS = 20,
  parameter int CODE_W      = 5,
  parameter int MAX_CODE    = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              lvl,
  output logic              apply,
  output logic              revert,
  output logic [CODE_W-1:0] apply_code
);
  localparam int M1    = (START_TICKS > STOP_TICKS) ? START_TICKS : STOP_TICKS;
  localparam int M2    = (OFF_TICKS > DELAY_TICKS) ? OFF_TICKS : DELAY_TICKS;
  localparam int CNT_W = $clog2(((M1 > M2) ? M1 : M2) + 1);

  dec_state_e        st_q, st_d;
  logic [CNT_W-1:0]  tcnt_q, tcnt_d;
  logic [CODE_W-1:0] pcnt_q, pcnt_d;
  logic              prev_q;
  logic              fall;

  assign fall = prev_q & ~lvl;

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    pcnt_d = pcnt_q;
    apply  = 1'b0;
    revert = 1'b0;
    if (!en) begin
      st_d   = ST_IDLE;
      tcnt_d = '0;
      pcnt_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (lvl) begin
            st_d   = ST_START;
            tcnt_d = '0;
          end else if (tick && tcnt_q != CNT_W'(OFF_TICKS)) begin
            tcnt_d = tcnt_q + 1'b1;
            if (tcnt_q == CNT_W'(OFF_TICKS - 1)) revert = 1'b1;
          end
        end
        ST_START: begin
          if (!lvl) begin
            st_d   = ST_IDLE;
            tcnt_d = '0;
          end else if (tick) begin
            if (tcnt_q == CNT_W'(START_TICKS - 1)) begin
              st_d   = ST_READY;
              tcnt_d = '0;
            end else begin
              tcnt_d = tcnt_q + 1'b1;
            end
          end
        end
        ST_READY: begin
          if (!lvl) begin
            st_d   = ST_FRAME;
            pcnt_d = CODE_W'(1);
            tcnt_d = '0;
          end
        end
        ST_FRAME: begin
          if (lvl != prev_q) begin
            tcnt_d = '0;
            if (fall && pcnt_q != CODE_W'(MAX_CODE)) pcnt_d = pcnt_q + 1'b1;
          end else if (tick) begin
            if (lvl && tcnt_q == CNT_W'(STOP_TICKS - 1)) begin
              st_d   = ST_HOLD;
              tcnt_d = '0;
            end else if (!lvl && tcnt_q == CNT_W'(OFF_TICKS - 1)) begin
              st_d   = ST_IDLE;
              tcnt_d = CNT_W'(OFF_TICKS);
              revert = 1'b1;
            end else begin
              tcnt_d = tcnt_q + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (tick) begin
            if (tcnt_q == CNT_W'(DELAY_TICKS - 1)) begin
              apply  = 1'b1;
              st_d   = ST_START;
              tcnt_d = '0;
            end else begin
              tcnt_d = tcnt_q + 1'b1;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      pcnt_q <= '0;
      prev_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      pcnt_q <= pcnt_d;
      prev_q <= lvl;
    end
  end

  assign apply_code = pcnt_q;

  // R2
  frame_has_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FRAME || st_q == ST_HOLD) |-> pcnt_q != '0);
  // R6
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= CODE_W'(MAX_CODE));
endmodule

// File: rtl/pcp_code_reg.sv
module pcp_code_reg #(
  parameter int CODE_W   = 5,
  parameter int MAX_CODE = 30,
  parameter int MV_W     = 11,
  parameter int BASE_MV  = 800,
  parameter int STEP_MV  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              apply,
  input  logic              revert,
  input  logic [CODE_W-1:0] apply_code,
  output logic [CODE_W-1:0] code,
  output logic [MV_W-1:0]   ref_mv,
  output logic              code_upd
);
  logic [CODE_W-1:0] code_q, code_d;
  logic              upd_q, upd_d;

  always_comb begin
    code_d = code_q;
    if (!en || revert) code_d = '0;
    else if (apply && apply_code != '0) code_d = apply_code;
    upd_d = (code_d != code_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      upd_q  <= upd_d;
    end
  end

  assign code     = code_q;
  assign code_upd = upd_q;
  assign ref_mv   = MV_W'(BASE_MV) + MV_W'(STEP_MV) * MV_W'(code_q);

  // R6
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= CODE_W'(MAX_CODE));
  // R8
  disabled_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> code_q == '0);
  // R10
  strobe_tracks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q == (code_q != $past(code_q)));
endmodule

// File: rtl/pulse_code_prog.sv
module pulse_code_prog #(
  parameter int FILT_TICKS  = 2,
  parameter int START_TICKS = 300,
  parameter int STOP_TICKS  = 300,
  parameter int OFF_TICKS   = 270,
  parameter int DELAY_TICKS = 20,
  parameter int CODE_W      = 5,
  parameter int MAX_CODE    = 30,
  parameter int MV_W        = 11,
  parameter int BASE_MV     = 800,
  parameter int STEP_MV     = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              line_in,
  input  logic              tick_us,
  output logic [CODE_W-1:0] code,
  output logic [MV_W-1:0]   ref_mv,
  output logic              code_upd
);
  logic              lvl, apply, revert;
  logic [CODE_W-1:0] apply_code;

  pcp_line_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .line_raw(line_in), .line_flt(lvl)
  );

  pcp_frame_dec #(
    .START_TICKS(START_TICKS), .STOP_TICKS(STOP_TICKS), .OFF_TICKS(OFF_TICKS),
    .DELAY_TICKS(DELAY_TICKS), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick_us), .lvl(lvl),
    .apply(apply), .revert(revert), .apply_code(apply_code)
  );

  pcp_code_reg #(
    .CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .MV_W(MV_W),
    .BASE_MV(BASE_MV), .STEP_MV(STEP_MV)
  ) u_code (
    .clk(clk), .rst_n(rst_n), .en(en), .apply(apply), .revert(revert),
    .apply_code(apply_code), .code(code), .ref_mv(ref_mv), .code_upd(code_upd)
  );
endmodule

// File: tb/pulse_code_prog_bench.sv
module pulse_code_prog_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        line_in = 1'b0;
  logic        tick_us = 1'b0;
  logic [4:0]  code;
  logic [10:0] ref_mv;
  logic        code_upd;

  int checks = 0;
  int errors = 0;
  int cur = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  pulse_code_prog u_pulse_code_prog (
    .clk(clk), .rst_n(rst_n), .en(en), .line_in(line_in), .tick_us(tick_us),
    .code(code), .ref_mv(ref_mv), .code_upd(code_upd)
  );

  initial begin
    forever begin
      @(negedge clk);
      tick_us = ~tick_us;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_t(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  // R10 scoreboard monitor: every strobe must match a queued expected code
  always @(negedge clk) begin
    if (rst_n && code_upd) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected strobe", int'(code), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(code) == e, "R10 strobe code", int'(code), e);
        chk(int'(ref_mv) == 800 + 15 * e, "R2 strobe ref_mv", int'(ref_mv), 800 + 15 * e);
      end
    end
  end

  task automatic pulses(input int n, input int lo, input int hi, input bit glitch);
    for (int i = 0; i < n; i++) begin
      line_in = 1'b0;
      if (glitch && i == 1) begin
        wait_t(lo / 2);
        line_in = 1'b1;
        @(negedge clk);
        line_in = 1'b0;
        wait_t(lo - lo / 2);
      end else begin
        wait_t(lo);
      end
      line_in = 1'b1;
      if (glitch && i == 2) begin
        wait_t(hi / 2);
        line_in = 1'b0;
        @(negedge clk);
        line_in = 1'b1;
        wait_t(hi - hi / 2);
      end else begin
        wait_t(hi);
      end
    end
  endtask

  task automatic send_frame(input int n, input int lo, input int hi, input bit glitch);
    int e, old;
    old = cur;
    e = (n > 30) ? 30 : n;
    if (e != cur) exp_q.push_back(e);
    line_in = 1'b1;
    wait_t(320);
    pulses(n, lo, hi, glitch);
    wait_t(310 - hi);
    // R4: stop interval done but settle delay not yet over
    chk(int'(code) == old, "R4 code before delay", int'(code), old);
    wait_t(hi + 30);
    chk(int'(code) == e, "R2 code after frame", int'(code), e);
    chk(int'(ref_mv) == 800 + 15 * e, "R2 ref_mv after frame", int'(ref_mv), 800 + 15 * e);
    cur = e;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1
    chk(code == 5'd0, "R1 reset code", int'(code), 0);
    chk(ref_mv == 11'd800, "R1 reset ref_mv", int'(ref_mv), 800);
    chk(code_upd == 1'b0, "R1 reset strobe", int'(code_upd), 0);
    rst_n = 1'b1;
    en = 1'b1;
    wait_t(10);

    send_frame(4, 40, 40, 1'b0);     // R2
    send_frame(2, 40, 40, 1'b0);     // R5 absolute replacement
    chk(int'(ref_mv) == 830, "R5 replace ref_mv", int'(ref_mv), 830);
    send_frame(3, 10, 10, 1'b0);     // R2 short widths
    send_frame(2, 120, 120, 1'b0);   // R2 long widths
    send_frame(35, 40, 40, 1'b0);    // R6 saturation
    chk(int'(ref_mv) == 1250, "R6 max ref_mv", int'(ref_mv), 1250);
    send_frame(30, 40, 40, 1'b0);    // R6 same code, no strobe
    send_frame(5, 40, 40, 1'b1);     // R9 glitches ignored

    // R7: long low reverts to default
    exp_q.push_back(0);
    line_in = 1'b0;
    wait_t(290);
    chk(int'(code) == 0, "R7 off revert", int'(code), 0);
    cur = 0;

    // R3: high shorter than start interval does not open a frame
    line_in = 1'b1;
    wait_t(100);
    pulses(3, 40, 40, 1'b0);
    wait_t(400);
    chk(int'(code) == 0, "R3 unqualified start", int'(code), 0);

    send_frame(6, 40, 40, 1'b0);

    // R8: disable forces default and ignores the line
    exp_q.push_back(0);
    en = 1'b0;
    wait_t(5);
    chk(int'(code) == 0, "R8 disable default", int'(code), 0);
    cur = 0;
    line_in = 1'b1;
    wait_t(320);
    pulses(3, 40, 40, 1'b0);
    wait_t(360);
    chk(int'(code) == 0, "R8 line ignored", int'(code), 0);
    en = 1'b1;
    send_frame(9, 40, 40, 1'b0);

    wait_t(20);
    // R10: every expected change was strobed
    chk(exp_q.size() == 0, "R10 missing strobes", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule